// File: doc/BRIEF.md
# Generation-Tagged Instruction Fetch with Consumer Redirect

This block is a single-issue instruction fetch stage joined to the stage that consumes its output. The fetch side keeps a 15-bit program counter and a small generation tag. In every cycle where its one-entry handoff register can take a new entry, it reads a 12-bit word from a synchronous instruction memory and loads the handoff register with the tag, the PC and that word. It then steps the PC forward inside the current 4096-word field.

The consumer side keeps its own copy of the tag and the PC it expects to run next. A bundle carrying an old tag is thrown away. A bundle with the current tag whose PC is not the expected one is not run. Instead the consumer bumps its tag and sends a restart carrying the new tag and the expected PC. The fetch side applies a restart before fetching in that same cycle, so the next bundle already comes from the right address. Execution itself is outside the block: the "executed" bundle is reported on an output port, and the next expected PC comes either from a sequential step or from a taken-branch target supplied at the inputs. The memory is filled through a plain write port.

Top module: `tagfetch_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bnd_valid`, `exec_valid` and `rsv_valid` are 0. The first bundle comes from `START_PC` with tag 0 and `bnd_restarted` = 0.
- R2: Every valid bundle holds the tag and PC it was fetched with. Its word equals the memory entry at index `pc[MEM_AW-1:0]` as last written through the load port.
- R3: A new bundle enters the handoff register, and the fetch PC advances, only when the register is empty or is being consumed in that cycle. Otherwise tag, PC, word and marker stay unchanged.
- R4: The PC steps by adding 1 to bits [11:0] modulo 4096 while bits [14:12] stay unchanged. This applies to fetch and to the consumer's expected PC, so after `3:7777` (octal) comes `3:0000`.
- R5: While `halt` is 1, the consumer takes nothing from the handoff register. A waiting bundle stays in place and no execution is reported.
- R6: A consumed bundle is executed only if its tag equals the consumer tag and its PC equals the expected PC. One cycle later `exec_valid` pulses with that bundle's PC and word. The expected PC becomes `br_target` if `br_take` is 1 in the consuming cycle; otherwise it takes the R4 step.
- R7: A consumed bundle with the current tag and a wrong PC is not executed. The consumer tag increments, and one cycle later `rsv_valid` pulses for one cycle with the new tag and the expected PC.
- R8: The restart takes effect in the consuming cycle. The bundle present in the next cycle carries the new tag, the expected PC and that PC's word, with `bnd_restarted` = 1. All other bundles have `bnd_restarted` = 0.
- R9: Tags are `TAG_W` bits (default 4) and wrap, so with the default width the 16th restart carries tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write enable of the memory fill port |
| ld_addr | input | MEM_AW | Memory fill address |
| ld_data | input | WORD_W | Memory fill data |
| halt | input | 1 | Consumer halted: nothing is taken from the handoff |
| br_take | input | 1 | The bundle executed this cycle redirects to `br_target` |
| br_target | input | 15 | Next expected PC when `br_take` is used |
| bnd_valid | output | 1 | Handoff register holds a bundle |
| bnd_tag | output | TAG_W | Generation tag of the bundle |
| bnd_pc | output | 15 | PC the bundle was fetched from |
| bnd_word | output | WORD_W | Fetched instruction word |
| bnd_restarted | output | 1 | First bundle after a restart |
| exec_valid | output | 1 | A bundle was executed in the previous cycle |
| exec_pc | output | 15 | PC of the executed bundle |
| exec_word | output | WORD_W | Word of the executed bundle |
| rsv_valid | output | 1 | A restart was issued in the previous cycle |
| rsv_tag | output | TAG_W | New tag carried by the restart |
| rsv_pc | output | 15 | PC carried by the restart |

## Verification
A wrong fetch PC or tag shows at the bundle ports as soon as the handoff register is next loaded, which is at most one cycle after it empties. A wrong expected PC or consumer tag in the consumer shows as a missing `exec_valid` and a spurious `rsv_valid` one cycle after the next bundle is consumed. A restart that is not applied in the same cycle shows as a wrong-PC bundle right after the mismatch, followed by a second restart. Tag wrap errors show only at the sixteenth restart, so the stimulus takes a branch often enough to get past it.

// File: rtl/tagfetch_pkg.sv
package tagfetch_pkg;
  localparam int PC_W    = 15;
  localparam int FIELD_W = 3;
  localparam int OFF_W   = PC_W - FIELD_W;

  typedef logic [PC_W-1:0] pc_t;

  // step inside the current field: the offset wraps, the field is kept
  function automatic pc_t pc_step(input pc_t p);
    logic [OFF_W-1:0] off;
    off = p[OFF_W-1:0] + 1'b1;
    return {p[PC_W-1:OFF_W], off};
  endfunction
endpackage

// File: rtl/tagfetch_imem.sv
module tagfetch_imem #(
  parameter int WORD_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [WORD_W-1:0] store [DEPTH];

  // one write port, one registered read port with enable: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tagfetch_fetch.sv
module tagfetch_fetch
  import tagfetch_pkg::*;
#(
  parameter int   TAG_W    = 4,
  parameter int   MEM_AW   = 8,
  parameter pc_t  START_PC = 15'h0010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_in,
  input  logic             rs_v,
  input  logic [TAG_W-1:0] rs_tag,
  input  pc_t              rs_pc,
  output logic             rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output pc_t              b_pc,
  output logic             b_mark
);
  pc_t              pc_q;
  logic [TAG_W-1:0] tag_q;
  logic             mark_pend_q;
  logic             fire;
  pc_t              cur_pc;
  logic [TAG_W-1:0] cur_tag;
  logic             emit_mark;

  // the handoff register accepts when empty or being drained this cycle
  assign fire      = !b_valid || take_in;
  // a restart is applied ahead of the fetch in the same cycle
  assign cur_pc    = rs_v ? rs_pc  : pc_q;
  assign cur_tag   = rs_v ? rs_tag : tag_q;
  assign emit_mark = rs_v || mark_pend_q;

  assign rd_en   = fire && !rst;
  assign rd_addr = cur_pc[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= START_PC;
      tag_q       <= '0;
      mark_pend_q <= 1'b0;
      b_valid     <= 1'b0;
      b_tag       <= '0;
      b_pc        <= START_PC;
      b_mark      <= 1'b0;
    end else begin
      if (rs_v) begin
        pc_q  <= rs_pc;
        tag_q <= rs_tag;
      end
      if (fire) begin
        b_valid     <= 1'b1;
        b_tag       <= cur_tag;
        b_pc        <= cur_pc;
        b_mark      <= emit_mark;
        pc_q        <= pc_step(cur_pc);
        tag_q       <= cur_tag;
        mark_pend_q <= 1'b0;
      end else if (rs_v) begin
        mark_pend_q <= 1'b1;
      end
    end
  end

  // R3
  hold_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !take_in) |=> (b_valid && $stable(b_pc) && $stable(b_tag) && $stable(b_mark)));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (b_valid && fire && !rs_v) |=> (b_pc == pc_step($past(b_pc))));

  // R8
  restart_mark_chk: assert property (@(posedge clk) disable iff (rst)
    rs_v |=> (b_valid && b_mark && b_pc == $past(rs_pc) && b_tag == $past(rs_tag)));
endmodule

// File: rtl/tagfetch_consumer.sv
module tagfetch_consumer
  import tagfetch_pkg::*;
#(
  parameter int   TAG_W    = 4,
  parameter int   WORD_W   = 12,
  parameter pc_t  START_PC = 15'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              br_take,
  input  pc_t               br_target,
  input  logic              b_valid,
  input  logic [TAG_W-1:0]  b_tag,
  input  pc_t               b_pc,
  input  logic [WORD_W-1:0] b_word,
  output logic              take,
  output logic              rs_v,
  output logic [TAG_W-1:0]  rs_tag,
  output pc_t               rs_pc,
  output logic              exec_valid,
  output pc_t               exec_pc,
  output logic [WORD_W-1:0] exec_word,
  output logic              rsv_valid,
  output logic [TAG_W-1:0]  rsv_tag,
  output pc_t               rsv_pc
);
  logic [TAG_W-1:0] ctag_q;
  pc_t              exp_q;
  logic             tag_hit;
  logic             pc_hit;
  logic             run_now;

  assign take    = b_valid && !halt;
  assign tag_hit = (b_tag == ctag_q);
  assign pc_hit  = (b_pc == exp_q);
  assign run_now = take && tag_hit && pc_hit;
  // stale tags fall through both paths and are simply dropped
  assign rs_v    = take && tag_hit && !pc_hit;
  assign rs_tag  = ctag_q + 1'b1;
  assign rs_pc   = exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctag_q     <= '0;
      exp_q      <= START_PC;
      exec_valid <= 1'b0;
      exec_pc    <= '0;
      exec_word  <= '0;
      rsv_valid  <= 1'b0;
      rsv_tag    <= '0;
      rsv_pc     <= '0;
    end else begin
      exec_valid <= run_now;
      rsv_valid  <= rs_v;
      if (run_now) begin
        exec_pc   <= b_pc;
        exec_word <= b_word;
        exp_q     <= br_take ? br_target : pc_step(exp_q);
      end
      if (rs_v) begin
        ctag_q  <= rs_tag;
        rsv_tag <= rs_tag;
        rsv_pc  <= exp_q;
      end
    end
  end

  // R5
  halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && b_valid) |=> (b_valid && $stable(b_pc) && $stable(b_tag) && !exec_valid));

  // R7
  restart_bumps_chk: assert property (@(posedge clk) disable iff (rst)
    rs_v |=> (rsv_valid && !exec_valid && ctag_q == $past(b_tag) + 1'b1));

  // R6
  exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> !rsv_valid);

  // R6
  exec_from_bundle_chk: assert property (@(posedge clk) disable iff (rst)
    (take && tag_hit && pc_hit) |=> (exec_valid && exec_pc == $past(b_pc)));
endmodule

// File: rtl/tagfetch_top.sv
module tagfetch_top
  import tagfetch_pkg::*;
#(
  parameter int   TAG_W    = 4,
  parameter int   WORD_W   = 12,
  parameter int   MEM_AW   = 8,
  parameter pc_t  START_PC = 15'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              halt,
  input  logic              br_take,
  input  logic [14:0]       br_target,
  output logic              bnd_valid,
  output logic [TAG_W-1:0]  bnd_tag,
  output logic [14:0]       bnd_pc,
  output logic [WORD_W-1:0] bnd_word,
  output logic              bnd_restarted,
  output logic              exec_valid,
  output logic [14:0]       exec_pc,
  output logic [WORD_W-1:0] exec_word,
  output logic              rsv_valid,
  output logic [TAG_W-1:0]  rsv_tag,
  output logic [14:0]       rsv_pc
);
  logic              take;
  logic              rs_v;
  logic [TAG_W-1:0]  rs_tag;
  pc_t               rs_pc;
  logic              rd_en;
  logic [MEM_AW-1:0] rd_addr;

  tagfetch_imem #(.WORD_W(WORD_W), .MEM_AW(MEM_AW)) u_imem (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .re(rd_en), .raddr(rd_addr), .rdata(bnd_word)
  );

  tagfetch_fetch #(.TAG_W(TAG_W), .MEM_AW(MEM_AW), .START_PC(START_PC)) u_fetch (
    .clk(clk), .rst(rst), .take_in(take),
    .rs_v(rs_v), .rs_tag(rs_tag), .rs_pc(rs_pc),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .b_valid(bnd_valid), .b_tag(bnd_tag), .b_pc(bnd_pc), .b_mark(bnd_restarted)
  );

  tagfetch_consumer #(.TAG_W(TAG_W), .WORD_W(WORD_W), .START_PC(START_PC)) u_cons (
    .clk(clk), .rst(rst), .halt(halt), .br_take(br_take), .br_target(br_target),
    .b_valid(bnd_valid), .b_tag(bnd_tag), .b_pc(bnd_pc), .b_word(bnd_word),
    .take(take), .rs_v(rs_v), .rs_tag(rs_tag), .rs_pc(rs_pc),
    .exec_valid(exec_valid), .exec_pc(exec_pc), .exec_word(exec_word),
    .rsv_valid(rsv_valid), .rsv_tag(rsv_tag), .rsv_pc(rsv_pc)
  );
endmodule

// File: tb/test_tagfetch_top.sv
`timescale 1ns/1ps
module test_tagfetch_top;
  localparam int          TAG_W  = 4;
  localparam int          WORD_W = 12;
  localparam int          MEM_AW = 8;
  localparam logic [14:0] START  = 15'h0010;
  localparam int          RUN    = 700;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [WORD_W-1:0] ld_data = '0;
  logic              halt = 1'b0;
  logic              br_take = 1'b0;
  logic [14:0]       br_target = '0;
  logic              bnd_valid, bnd_restarted, exec_valid, rsv_valid;
  logic [TAG_W-1:0]  bnd_tag, rsv_tag;
  logic [14:0]       bnd_pc, exec_pc, rsv_pc;
  logic [WORD_W-1:0] bnd_word, exec_word;

  always #10 clk = ~clk;

  tagfetch_top #(.TAG_W(TAG_W), .WORD_W(WORD_W), .MEM_AW(MEM_AW), .START_PC(START)) i_tagfetch_top (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .halt(halt), .br_take(br_take), .br_target(br_target),
    .bnd_valid(bnd_valid), .bnd_tag(bnd_tag), .bnd_pc(bnd_pc), .bnd_word(bnd_word),
    .bnd_restarted(bnd_restarted), .exec_valid(exec_valid), .exec_pc(exec_pc),
    .exec_word(exec_word), .rsv_valid(rsv_valid), .rsv_tag(rsv_tag), .rsv_pc(rsv_pc)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [26:0] exec_q[$];   // {pc, word}
  logic [18:0] rst_q[$];    // {tag, pc}

  // bench model state
  logic [TAG_W-1:0] m_ctag, m_ftag;
  logic [14:0]      m_exp, m_fpc;
  logic             p_valid, p_mark;
  logic [TAG_W-1:0] p_tag;
  logic [14:0]      p_pc;
  int               n_exec, n_rst;
  bit               saw_wrap_pc;

  function automatic logic [WORD_W-1:0] mem_val(input logic [14:0] p);
    int unsigned idx;
    idx = p[MEM_AW-1:0];
    return WORD_W'((idx * 173 + 29) & 12'hFFF);
  endfunction

  function automatic logic [14:0] step(input logic [14:0] p);
    return {p[14:12], 12'(p[11:0] + 12'd1)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected results of a consuming cycle
  task automatic push_exec(input logic [14:0] pc);
    exec_q.push_back({pc, mem_val(pc)});
  endtask

  task automatic push_restart(input logic [TAG_W-1:0] t, input logic [14:0] pc);
    rst_q.push_back({t, pc});
  endtask

  // monitor side: outputs due this cycle
  task automatic monitor();
    logic [26:0] e;
    logic [18:0] r;
    if (p_valid !== bnd_valid) check("R3 bundle valid", 32'(bnd_valid), 32'(p_valid));
    else compared++;
    if (p_valid) begin
      check("R2 bundle tag", 32'(bnd_tag), 32'(p_tag));
      check("R2 bundle pc", 32'(bnd_pc), 32'(p_pc));
      check("R2 bundle word", 32'(bnd_word), 32'(mem_val(p_pc)));
      check("R8 restarted marker", 32'(bnd_restarted), 32'(p_mark));
    end
    if (exec_q.size() != 0) begin
      e = exec_q.pop_front();
      check("R6 exec valid", 32'(exec_valid), 32'd1);
      check("R6 exec pc", 32'(exec_pc), 32'(e[26:12]));
      check("R6 exec word", 32'(exec_word), 32'(e[11:0]));
      if (exec_valid && exec_pc == 15'o30000) saw_wrap_pc = 1'b1;
    end else begin
      check("R5 R7 no exec", 32'(exec_valid), 32'd0);
    end
    if (rst_q.size() != 0) begin
      r = rst_q.pop_front();
      check("R7 restart valid", 32'(rsv_valid), 32'd1);
      check("R7 restart tag", 32'(rsv_tag), 32'(r[18:15]));
      check("R7 restart pc", 32'(rsv_pc), 32'(r[14:0]));
      if (n_rst == 16) check("R9 tag wrap to zero", 32'(rsv_tag), 32'd0);
    end else begin
      check("R7 no restart", 32'(rsv_valid), 32'd0);
    end
  endtask

  // one cycle of stimulus and prediction, using the bundle now visible
  task automatic drive(input int cyc);
    logic pop, rs, fire, tk;
    logic [14:0] tgt;
    int k;
    halt = (cyc >= 30 && cyc <= 34) || cyc == 90 || (cyc >= 150 && cyc <= 152);
    k    = n_exec;
    tk   = (k % 3 == 2);
    tgt  = (k == 5) ? 15'o37777 : {3'(k % 8), 12'((k * 389 + 1000) & 12'hFFF)};
    br_take   = tk;
    br_target = tgt;
    pop = bnd_valid && !halt;
    rs  = 1'b0;
    if (pop && bnd_tag == m_ctag) begin
      if (bnd_pc != m_exp) begin
        rs = 1'b1;
        m_ctag = m_ctag + 1'b1;
        n_rst++;
        push_restart(m_ctag, m_exp);
        m_fpc  = m_exp;
        m_ftag = m_ctag;
      end else begin
        push_exec(bnd_pc);
        n_exec++;
        m_exp = tk ? tgt : step(m_exp);
      end
    end
    fire = !bnd_valid || pop;
    if (fire) begin
      p_valid = 1'b1;
      p_tag   = m_ftag;
      p_pc    = m_fpc;
      p_mark  = rs;
      m_fpc   = step(m_fpc);
    end else begin
      p_valid = bnd_valid;
      p_tag   = bnd_tag;
      p_pc    = bnd_pc;
      p_mark  = bnd_restarted;
    end
  endtask

  initial begin
    m_ctag = '0; m_ftag = '0; m_exp = START; m_fpc = START;
    p_valid = 1'b0; p_tag = '0; p_pc = START; p_mark = 1'b0;
    n_exec = 0; n_rst = 0; saw_wrap_pc = 1'b0;
    // fill memory while held in reset
    for (int i = 0; i < (1 << MEM_AW); i++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = MEM_AW'(i);
      ld_data = mem_val(15'(i));
      check("R1 held in reset", 32'({bnd_valid, exec_valid, rsv_valid}), 32'd0);
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst   = 1'b0;
    check("R1 bundle empty after reset", 32'(bnd_valid), 32'd0);
    check("R1 no exec after reset", 32'(exec_valid), 32'd0);
    check("R1 no restart after reset", 32'(rsv_valid), 32'd0);
    drive(0);
    for (int c = 1; c < RUN; c++) begin
      @(negedge clk);
      if (c == 1) begin
        check("R1 first bundle pc", 32'(bnd_pc), 32'(START));
        check("R1 first bundle tag", 32'(bnd_tag), 32'd0);
      end
      monitor();
      drive(c);
    end
    @(negedge clk);
    monitor();
    check("R4 field kept on offset wrap", 32'(saw_wrap_pc), 32'd1);
    check("R9 enough restarts for wrap", 32'(n_rst >= 17), 32'd1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule